// File: doc/BRIEF.md
# Serial Wiper Stepper

This block holds a bank of 8-bit wiper tap registers and moves one of them a single tap at a time while a serial stepping session is open. The command decoder that parses the serial instruction stream raises `step_enable` for one cycle, together with the selected pot index, once the stepping instruction byte has been taken in. From then on, every serial clock rising edge reaches the block as a one-cycle `sck_rise` strobe that carries the serial data level. A high level moves the selected wiper one tap toward the high end of the ladder. A low level moves it one tap toward the low end.

The session stays open for the rest of the chip-select frame and closes as soon as `cs_n` is sampled high. Stepping touches only the volatile tap registers. Each real move raises a one-cycle change strobe that carries the pot index and the new tap value. A settle flag then stays high for a fixed number of cycles, so that a downstream model of wiper response delay can be applied.

Top module: `wiper_stepper`

## Requirements
- R1: After reset every tap register holds RESET_TAP, and `wiper_changed` and `wiper_settling` are low.
- R2: A `sck_rise` strobe has no effect unless a session has been opened by `step_enable` earlier in the current low period of `cs_n`.
- R3: In an open session, each `sck_rise` with `si_level`=1 adds one to the selected tap and with `si_level`=0 subtracts one. No other tap changes. The new value appears on `wiper_flat` (tap i at bits i*8+7..i*8) one cycle after the strobe.
- R4: A step up at 255 or a step down at 0 leaves the tap unchanged and raises no change strobe.
- R5: Sampling `cs_n` high closes the session. Later strobes do nothing until a new `step_enable` arrives.
- R6: Every real move raises `wiper_changed` for exactly one cycle, in the same cycle as the new tap value, with `changed_idx` set to the pot index and `changed_value` set to the new value.
- R7: `wiper_settling` is high for exactly SETTLE_CYCLES cycles, starting in the cycle that `wiper_changed` is high. A new move restarts this window.
- R8: A `step_enable` while `cs_n` is high opens no session.
- R9: A `sck_rise` in the same cycle as the `step_enable` that opens the session is not counted as a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low; high ends the session |
| step_enable | input | 1 | One-cycle pulse from the decoder that opens a session |
| pot_sel | input | IDX_W | Pot index, taken when `step_enable` is high |
| sck_rise | input | 1 | One-cycle strobe for each serial clock rising edge |
| si_level | input | 1 | Serial data level that goes with `sck_rise` |
| wiper_flat | output | NUM_POTS*TAP_W | All tap registers packed together, pot 0 in the low bits |
| wiper_changed | output | 1 | One-cycle strobe for each real move |
| changed_idx | output | IDX_W | Index of the pot that moved |
| changed_value | output | TAP_W | New tap value of the pot that moved |
| wiper_settling | output | 1 | High while the settle window after the last move runs |

## Verification
A strobe sampled at clock edge E updates the tap register, `wiper_changed` and the settle counter at E itself. The bench drives inputs on falling edges and checks every result at the falling edge right after E, which is one cycle of latency. It then confirms at the next falling edge that the change strobe has dropped. The settle flag is checked at the falling edges after E+SETTLE_CYCLES-1, where it must still be high, and after E+SETTLE_CYCLES, where it must be low. Session opening and closing happen at the edge where `step_enable` or `cs_n` is sampled, so a strobe one cycle later already sees the new session state.

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
  parameter int NUM_POTS      = 4,
  parameter int TAP_W         = 8,
  parameter int RESET_TAP     = 128,
  parameter int SETTLE_CYCLES = 20,
  localparam int IDX_W  = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
  localparam int FLAT_W = NUM_POTS * TAP_W,
  localparam int CNT_W  = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             step_enable,
  input  logic [IDX_W-1:0] pot_sel,
  input  logic             sck_rise,
  input  logic             si_level,
  output logic [FLAT_W-1:0] wiper_flat,
  output logic             wiper_changed,
  output logic [IDX_W-1:0] changed_idx,
  output logic [TAP_W-1:0] changed_value,
  output logic             wiper_settling
);

  logic             active_q;
  logic [IDX_W-1:0] sel_q;
  logic [TAP_W-1:0] tap_q [NUM_POTS];
  logic [CNT_W-1:0] settle_q;

  wire              step  = active_q && sck_rise && !cs_n;
  wire [TAP_W-1:0]  cur   = tap_q[sel_q];
  wire              moves = step && (si_level ? !(&cur) : (|cur));
  wire [TAP_W-1:0]  nxt   = si_level ? cur + 1'b1 : cur - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sel_q    <= '0;
    end else if (cs_n) begin
      active_q <= 1'b0;
    end else if (step_enable) begin
      active_q <= 1'b1;
      sel_q    <= pot_sel;
    end
  end

  for (genvar i = 0; i < NUM_POTS; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tap_q[i] <= TAP_W'(RESET_TAP);
      else if (moves && sel_q == IDX_W'(i))
        tap_q[i] <= nxt;
    end
    assign wiper_flat[i*TAP_W +: TAP_W] = tap_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_changed <= 1'b0;
      changed_idx   <= '0;
      changed_value <= '0;
      settle_q      <= '0;
    end else begin
      wiper_changed <= moves;
      if (moves) begin
        changed_idx   <= sel_q;
        changed_value <= nxt;
        settle_q      <= CNT_W'(SETTLE_CYCLES);
      end else if (settle_q != '0) begin
        settle_q <= settle_q - 1'b1;
      end
    end
  end

  assign wiper_settling = (settle_q != '0);

endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int NUM_POTS = 4,
  parameter int TAP_W    = 8,
  localparam int IDX_W  = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
  localparam int FLAT_W = NUM_POTS * TAP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic [FLAT_W-1:0] wiper_flat,
  input logic              wiper_changed,
  input logic [IDX_W-1:0]  changed_idx,
  input logic [TAP_W-1:0]  changed_value,
  input logic              wiper_settling
);

  logic [FLAT_W-1:0] prev_flat;
  always_ff @(posedge clk) prev_flat <= wiper_flat;

  wire [TAP_W-1:0] step_diff = changed_value - prev_flat[changed_idx*TAP_W +: TAP_W];

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_changed |-> (step_diff == TAP_W'(1) || step_diff == {TAP_W{1'b1}})); // R3

  AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_changed |-> changed_value == wiper_flat[changed_idx*TAP_W +: TAP_W]); // R6

  AST_MOVE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_flat) |-> wiper_changed); // R6

  AST_CS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(wiper_flat)); // R5

  AST_SETTLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_changed |-> wiper_settling); // R7

endmodule

bind wiper_stepper wiper_stepper_chk #(.NUM_POTS(NUM_POTS), .TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wiper_flat(wiper_flat),
  .wiper_changed(wiper_changed), .changed_idx(changed_idx),
  .changed_value(changed_value), .wiper_settling(wiper_settling));

// File: tb/wiper_stepper_tb.sv
module wiper_stepper_tb;
  localparam int NP = 4;
  localparam int TW = 8;
  localparam int RT = 128;
  localparam int SC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic step_enable = 1'b0;
  logic [1:0] pot_sel = '0;
  logic sck_rise = 1'b0;
  logic si_level = 1'b0;
  logic [NP*TW-1:0] wiper_flat;
  logic wiper_changed;
  logic [1:0] changed_idx;
  logic [TW-1:0] changed_value;
  logic wiper_settling;

  int checks = 0;
  int fails = 0;
  logic [TW-1:0] exp_tap [NP];
  bit m_active = 0;
  int m_sel = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wiper_stepper #(.NUM_POTS(NP), .TAP_W(TW), .RESET_TAP(RT), .SETTLE_CYCLES(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .step_enable(step_enable),
    .pot_sel(pot_sel), .sck_rise(sck_rise), .si_level(si_level),
    .wiper_flat(wiper_flat), .wiper_changed(wiper_changed),
    .changed_idx(changed_idx), .changed_value(changed_value),
    .wiper_settling(wiper_settling));

  function automatic logic [TW-1:0] sat_step(logic [TW-1:0] v, bit up);
    if (up) return (v == 8'hFF) ? v : v + 1'b1;
    return (v == 8'h00) ? v : v - 1'b1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_taps(string req);
    for (int i = 0; i < NP; i++) chk(req, wiper_flat[i*TW +: TW], exp_tap[i]);
  endtask

  task automatic open_session(int p);
    step_enable = 1'b1; pot_sel = 2'(p);
    @(negedge clk);
    step_enable = 1'b0;
    if (!cs_n) begin m_active = 1; m_sel = p; end
  endtask

  task automatic close_frame();
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    m_active = 0;
  endtask

  // one strobe, result checked one cycle later, strobe drop checked after that
  task automatic step(bit up, string req);
    logic [TW-1:0] nv;
    bit mv;
    sck_rise = 1'b1; si_level = up;
    @(negedge clk);
    sck_rise = 1'b0;
    mv = 0;
    if (m_active && !cs_n) begin
      nv = sat_step(exp_tap[m_sel], up);
      mv = (nv != exp_tap[m_sel]);
      exp_tap[m_sel] = nv;
    end
    chk(req, wiper_changed, mv);
    if (mv) begin
      chk("R6", changed_idx, m_sel);
      chk("R6", changed_value, exp_tap[m_sel]);
      chk("R7", wiper_settling, 1);
    end
    chk_taps(req);
    @(negedge clk);
    chk("R6", wiper_changed, 0);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) exp_tap[i] = TW'(RT);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_taps("R1");
    chk("R1", wiper_changed, 0);
    chk("R1", wiper_settling, 0);

    cs_n = 1'b0;
    @(negedge clk);
    step(1, "R2");

    open_session(2);
    step(1, "R3"); step(1, "R3"); step(0, "R3");

    // settle window: last move at edge E, sampled at negedge after E already
    repeat (SC - 2) @(negedge clk);
    chk("R7", wiper_settling, 1);
    @(negedge clk);
    chk("R7", wiper_settling, 0);

    // retrigger
    step(1, "R7");
    step(0, "R7");
    repeat (SC - 2) @(negedge clk);
    chk("R7", wiper_settling, 1);
    @(negedge clk);
    chk("R7", wiper_settling, 0);

    for (int k = 0; k < 130; k++) step(1, "R3");
    chk("R4", exp_tap[2], 255);
    step(1, "R4");
    for (int k = 0; k < 256; k++) step(0, "R3");
    step(0, "R4");

    close_frame();
    step(1, "R5");
    step(0, "R5");

    cs_n = 1'b1;
    open_session(1);
    cs_n = 1'b0;
    @(negedge clk);
    step(1, "R8");

    step_enable = 1'b1; pot_sel = 2'd3; sck_rise = 1'b1; si_level = 1'b1;
    @(negedge clk);
    step_enable = 1'b0; sck_rise = 1'b0;
    m_active = 1; m_sel = 3;
    chk("R9", wiper_changed, 0);
    chk_taps("R9");
    step(1, "R3");

    void'($urandom(32'd4242));
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 7) step(bit'($urandom_range(0, 1)), "R3");
      else if (op == 7) close_frame();
      else open_session($urandom_range(0, NP - 1));
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule